// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller

This block collects 96 level-sensitive interrupt request lines and presents them to a processor as a single interrupt output. Each source has a mask bit. The mask bits are grouped into banks of 32. Software changes a mask only through atomic write-one-to-set and write-one-to-clear ports, so no read-modify-write sequence is needed. Each source also has a 6-bit priority.

When no selection is outstanding, the controller picks the highest-priority unmasked pending source and holds its number in an active-interrupt register. That number stays fixed until software writes an acknowledge bit. If the chosen source has gone away, or has been masked, by the time the register is read, the upper field of the read value flags it as spurious.

A soft reset returns all state to its reset values within a fixed number of cycles and reports completion through a status bit. A configuration bit for automatic idle, a revision register and a few plain read/write housekeeping registers complete the map. All access goes through a simple 32-bit register port whose read data is valid one cycle after the read strobe.

Top module: `irqc_top`

## Requirements
- R1: After reset all three banks read 0xFFFFFFFF at their mask registers (every source masked). Every priority reads 0. Status bit 0 at 0x14 reads 1 once the reset sequence has finished, and irq_o is low.
- R2: A write to the set port at 0x8C + 0x20*b masks every source of bank b whose data bit is 1. Zero bits leave the mask unchanged. The mask reads back at 0x84 + 0x20*b, with bit i of bank b belonging to source 32*b + i.
- R3: A write to the clear port at 0x88 + 0x20*b unmasks every source of bank b whose data bit is 1. Zero bits leave the mask unchanged.
- R4: The pending register at 0x98 + 0x20*b reads raw input AND NOT mask for bank b. Writes to the mask register address and to the pending register address are ignored.
- R5: The controller selects among pending sources by the larger 6-bit priority value. Ties go to the lower source number. Selection happens on the first clock edge at which a source is pending and nothing is latched.
- R6: irq_o is high while a selection is latched. The latched number does not change until it is acknowledged, even if a higher-priority source becomes pending.
- R7: A read of 0x40 returns the latched source number in bits 6:0. Bits 31:7 are all zero when the latched source is still pending. They are all one (spurious) when it is no longer pending or when nothing is latched.
- R8: Writing 1 to bit 0 of 0x48 releases the latch, and irq_o falls on that edge. A new selection is made on the next edge if a source is pending.
- R9: Writing 1 to bit 1 of 0x10 starts a soft reset. Status bit 0 reads 0 for RST_CYCLES cycles and then reads 1. Register writes during that window are ignored. Afterwards every source is masked, and all priorities, housekeeping registers, the autoidle bit and the latch are cleared.
- R10: Bit 0 of 0x10 holds the autoidle setting, which drives autoidle_o and reads back. Bit 1 of 0x10 reads 0.
- R11: The revision register at 0x00 returns the major version in bits 7:4 and the minor version in bits 3:0 (default 0x21).
- R12: Priority n at 0x100 + 4*n keeps its low 6 bits. The threshold register at 0x68 keeps 8 bits, the protection register at 0x4C keeps 1 bit and the idle register at 0x50 keeps 2 bits. Each reads back with its unused bits as zero.
- R13: A read of an address outside the map returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe; data valid the next cycle |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_src | input | NUM_SRC (96) | Level-sensitive interrupt requests |
| irq_o | output | 1 | Interrupt to the processor |
| autoidle_o | output | 1 | Autoidle configuration bit |

## Verification
The hardest case to reach from the ports is a source that is latched and then goes away before the active register is read. The stimulus waits for the selection to be taken, drops that request line, and then reads the active register, which must show the same number with the spurious field set. A second hard case is a higher-priority source that arrives while a selection is held. The bench unmasks a priority-63 source after a priority-0 source has been latched, shows that the latch stays fixed, and shows that the new source wins only after the acknowledge write, with irq_o low for exactly one cycle. Soft-reset write blocking is reached by issuing a clear-port write on the cycle right after the reset request.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [3:0] {
    RG_NONE, RG_REV, RG_CFG, RG_STAT, RG_ACTIVE, RG_CTRL, RG_PROT,
    RG_IDLE, RG_THRESH, RG_MASK, RG_MCLR, RG_MSET, RG_PEND, RG_PRIO
  } reg_sel_e;

  localparam int OFS_REV     = 'h000;
  localparam int OFS_CFG     = 'h010;
  localparam int OFS_STAT    = 'h014;
  localparam int OFS_ACTIVE  = 'h040;
  localparam int OFS_CTRL    = 'h048;
  localparam int OFS_PROT    = 'h04C;
  localparam int OFS_IDLE    = 'h050;
  localparam int OFS_THRESH  = 'h068;
  localparam int BANK_BASE   = 'h080;
  localparam int BANK_STRIDE = 'h020;
  localparam int SUB_MASK    = 'h04;
  localparam int SUB_MCLR    = 'h08;
  localparam int SUB_MSET    = 'h0C;
  localparam int SUB_PEND    = 'h18;
  localparam int PRIO_BASE   = 'h100;

  localparam int CFG_IDLE_BIT = 0;
  localparam int CFG_SRST_BIT = 1;
  localparam int CTRL_ACK_BIT = 0;

endpackage

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_o
);

  always_ff @(posedge clk) begin
    if (clear)       mask_o <= '1;
    else if (set_we) mask_o <= mask_o | wdata;
    else if (clr_we) mask_o <= mask_o & ~wdata;
  end

  // R2
  mset_applied_chk: assert property (@(posedge clk) disable iff (rst)
    (set_we && !clear) |=> ((mask_o & $past(wdata)) == $past(wdata)));

  // R3
  mclr_applied_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !set_we && !clear) |=> ((mask_o & $past(wdata)) == '0));

endmodule

// File: rtl/irqc_prio_file.sv
module irqc_prio_file #(
  parameter int NUM_SRC = 96,
  parameter int PRIO_W  = 6,
  parameter int IDX_W   = 7
) (
  input  logic                      clk,
  input  logic                      clear,
  input  logic                      we,
  input  logic [IDX_W-1:0]          widx,
  input  logic [PRIO_W-1:0]         wdata,
  output logic [NUM_SRC*PRIO_W-1:0] prio_flat
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_ent
    logic [PRIO_W-1:0] level_q;
    always_ff @(posedge clk) begin
      if (clear)                          level_q <= '0;
      else if (we && widx == IDX_W'(g))   level_q <= wdata;
    end
    assign prio_flat[g*PRIO_W +: PRIO_W] = level_q;
  end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int NUM_SRC = 96,
  parameter int PRIO_W  = 6,
  parameter int ID_W    = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic                      any_o,
  output logic [ID_W-1:0]           win_o
);

  logic [PRIO_W-1:0] best;

  // Ascending scan with strict compare: the lowest index keeps a tie.
  always_comb begin
    any_o = 1'b0;
    win_o = '0;
    best  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_i[i] && (!any_o || prio_i[i*PRIO_W +: PRIO_W] > best)) begin
        any_o = 1'b1;
        best  = prio_i[i*PRIO_W +: PRIO_W];
        win_o = ID_W'(i);
      end
    end
  end

  // R5
  win_pending_chk: assert property (@(posedge clk) disable iff (rst)
    any_o |-> pend_i[win_o]);

endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int          NUM_SRC    = 96,
  parameter int          BANK_W     = 32,
  parameter int          PRIO_W     = 6,
  parameter int          ADDR_W     = 12,
  parameter int          RST_CYCLES = 4,
  parameter logic [3:0]  REV_MAJOR  = 4'h2,
  parameter logic [3:0]  REV_MINOR  = 4'h1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr_en,
  input  logic                bus_rd_en,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_SRC-1:0]  irq_src,
  output logic                irq_o,
  output logic                autoidle_o
);
  import irqc_pkg::*;

  localparam int NBANKS = NUM_SRC / BANK_W;
  localparam int BIDX_W = (NBANKS > 1) ? $clog2(NBANKS) : 1;
  localparam int ID_W   = 7;
  localparam int PIDX_W = $clog2(NUM_SRC);
  localparam int CNT_W  = $clog2(RST_CYCLES + 1);

  // ---------------- address decode ----------------
  reg_sel_e          sel;
  logic [BIDX_W-1:0] bank_idx;
  logic [PIDX_W-1:0] prio_idx;

  always_comb begin
    int a;
    int boff;
    a        = int'(bus_addr);
    boff     = 0;
    sel      = RG_NONE;
    bank_idx = '0;
    prio_idx = '0;
    if      (a == OFS_REV)    sel = RG_REV;
    else if (a == OFS_CFG)    sel = RG_CFG;
    else if (a == OFS_STAT)   sel = RG_STAT;
    else if (a == OFS_ACTIVE) sel = RG_ACTIVE;
    else if (a == OFS_CTRL)   sel = RG_CTRL;
    else if (a == OFS_PROT)   sel = RG_PROT;
    else if (a == OFS_IDLE)   sel = RG_IDLE;
    else if (a == OFS_THRESH) sel = RG_THRESH;
    else if (a >= BANK_BASE && a < BANK_BASE + NBANKS * BANK_STRIDE) begin
      boff     = a - BANK_BASE;
      bank_idx = BIDX_W'(boff / BANK_STRIDE);
      case (boff % BANK_STRIDE)
        SUB_MASK: sel = RG_MASK;
        SUB_MCLR: sel = RG_MCLR;
        SUB_MSET: sel = RG_MSET;
        SUB_PEND: sel = RG_PEND;
        default:  sel = RG_NONE;
      endcase
    end else if (a >= PRIO_BASE && a < PRIO_BASE + 4 * NUM_SRC && (a % 4) == 0) begin
      sel      = RG_PRIO;
      prio_idx = PIDX_W'((a - PRIO_BASE) / 4);
    end
  end

  // ---------------- soft reset sequencing ----------------
  logic [CNT_W-1:0] rst_cnt;
  logic             busy, srst_req, sclr, ack_wr;

  assign busy     = (rst_cnt != '0);
  assign srst_req = bus_wr_en && (sel == RG_CFG) && bus_wdata[CFG_SRST_BIT];
  assign sclr     = rst || busy || srst_req;
  assign ack_wr   = bus_wr_en && (sel == RG_CTRL) && bus_wdata[CTRL_ACK_BIT];

  always_ff @(posedge clk) begin
    if (rst || srst_req) rst_cnt <= CNT_W'(RST_CYCLES);
    else if (busy)       rst_cnt <= rst_cnt - 1'b1;
  end

  // ---------------- plain configuration registers ----------------
  logic       prot_q;
  logic [1:0] idle_q;
  logic [7:0] thresh_q;

  always_ff @(posedge clk) begin
    if (sclr) begin
      autoidle_o <= 1'b0;
      prot_q     <= 1'b0;
      idle_q     <= '0;
      thresh_q   <= '0;
    end else if (bus_wr_en) begin
      case (sel)
        RG_CFG:    autoidle_o <= bus_wdata[CFG_IDLE_BIT];
        RG_PROT:   prot_q     <= bus_wdata[0];
        RG_IDLE:   idle_q     <= bus_wdata[1:0];
        RG_THRESH: thresh_q   <= bus_wdata[7:0];
        default: ;
      endcase
    end
  end

  // ---------------- mask banks ----------------
  logic [NUM_SRC-1:0] mask_all;
  logic [NUM_SRC-1:0] pend;

  for (genvar g = 0; g < NBANKS; g++) begin : g_bank
    logic set_we, clr_we;
    assign set_we = bus_wr_en && (sel == RG_MSET) && (bank_idx == BIDX_W'(g));
    assign clr_we = bus_wr_en && (sel == RG_MCLR) && (bank_idx == BIDX_W'(g));
    irqc_mask_bank #(.W(BANK_W)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .clear  (sclr),
      .set_we (set_we),
      .clr_we (clr_we),
      .wdata  (bus_wdata[BANK_W-1:0]),
      .mask_o (mask_all[g*BANK_W +: BANK_W])
    );
  end

  assign pend = irq_src & ~mask_all;

  // ---------------- priorities and arbitration ----------------
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic                      any_pend;
  logic [ID_W-1:0]           win_id;

  irqc_prio_file #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(PIDX_W)) u_prio (
    .clk       (clk),
    .clear     (sclr),
    .we        (bus_wr_en && (sel == RG_PRIO)),
    .widx      (prio_idx),
    .wdata     (bus_wdata[PRIO_W-1:0]),
    .prio_flat (prio_flat)
  );

  irqc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
    .clk    (clk),
    .rst    (rst),
    .pend_i (pend),
    .prio_i (prio_flat),
    .any_o  (any_pend),
    .win_o  (win_id)
  );

  // ---------------- latched selection ----------------
  logic            latch_vld;
  logic [ID_W-1:0] latch_id;
  logic            latch_hit;

  always_ff @(posedge clk) begin
    if (sclr) begin
      latch_vld <= 1'b0;
      latch_id  <= '0;
    end else if (ack_wr) begin
      latch_vld <= 1'b0;
    end else if (!latch_vld && any_pend) begin
      latch_vld <= 1'b1;
      latch_id  <= win_id;
    end
  end

  assign irq_o = latch_vld;

  always_comb begin
    latch_hit = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (latch_id == ID_W'(i)) latch_hit = pend[i];
  end

  // ---------------- read path ----------------
  logic        spur;
  logic [31:0] rd_mux;

  assign spur = !latch_vld || !latch_hit;

  always_comb begin
    rd_mux = '0;
    case (sel)
      RG_REV:    rd_mux = {24'b0, REV_MAJOR, REV_MINOR};
      RG_CFG:    rd_mux = {31'b0, autoidle_o};
      RG_STAT:   rd_mux = {31'b0, !busy};
      RG_ACTIVE: rd_mux = {{(32-ID_W){spur}}, latch_id};
      RG_PROT:   rd_mux = {31'b0, prot_q};
      RG_IDLE:   rd_mux = {30'b0, idle_q};
      RG_THRESH: rd_mux = {24'b0, thresh_q};
      RG_MASK:   rd_mux = 32'(mask_all[int'(bank_idx)*BANK_W +: BANK_W]);
      RG_PEND:   rd_mux = 32'(pend[int'(bank_idx)*BANK_W +: BANK_W]);
      RG_PRIO:   rd_mux = 32'(prio_flat[int'(prio_idx)*PRIO_W +: PRIO_W]);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_mux;
  end

  // ---------------- assertions ----------------
  // R6
  sel_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !ack_wr && !sclr) |=> (irq_o && $stable(latch_id)));

  // R8
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ack_wr |=> !irq_o);

  // R9
  srst_busy_chk: assert property (@(posedge clk) disable iff (rst)
    srst_req |=> (busy && !irq_o && !autoidle_o));

endmodule

// File: tb/irqc_top_tb_top.sv
`timescale 1ns/1ps
module irqc_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr = 1'b0, rd = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [95:0] src = '0;
  logic        irq, autoidle;

  int          n_checks = 0;
  int          n_errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  logic [31:0] mon_exp;
  string       mon_tag;

  always #4 clk = ~clk;

  irqc_top dut_i (
    .clk        (clk),
    .rst        (rst),
    .bus_wr_en  (wr),
    .bus_rd_en  (rd),
    .bus_addr   (addr),
    .bus_wdata  (wdata),
    .bus_rdata  (rdata),
    .irq_src    (src),
    .irq_o      (irq),
    .autoidle_o (autoidle)
  );

  // Monitor: pops the expected value for each read one cycle after the strobe.
  always @(posedge clk) rd_seen <= rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      mon_exp = exp_q.pop_front();
      mon_tag = tag_q.pop_front();
      n_checks++;
      if (rdata !== mon_exp) begin
        n_errors++;
        $display("FAIL %s: got %h expected %h", mon_tag, rdata, mon_exp);
      end
    end
  end

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [11:0] a, input logic [31:0] e, input string t);
    addr = a; rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_bit(input logic act, input logic e, input string t);
    n_checks++;
    if (act !== e) begin
      n_errors++;
      $display("FAIL %s: got %b expected %b", t, act, e);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(8);

    // R1 reset state, R11 revision
    rd_reg(12'h014, 32'h1, "R1 status done");
    rd_reg(12'h084, 32'hFFFF_FFFF, "R1 bank0 mask");
    rd_reg(12'h0A4, 32'hFFFF_FFFF, "R1 bank1 mask");
    rd_reg(12'h0C4, 32'hFFFF_FFFF, "R1 bank2 mask");
    rd_reg(12'h114, 32'h0, "R1 prio5 zero");
    rd_reg(12'h000, 32'h21, "R11 revision");
    chk_bit(irq, 1'b0, "R1 irq low");
    rd_reg(12'h040, 32'hFFFF_FF80, "R7 nothing latched");

    // R12 readback widths
    wr_reg(12'h114, 32'hFF);
    rd_reg(12'h114, 32'h3F, "R12 prio5");
    wr_reg(12'h068, 32'hABCD);
    rd_reg(12'h068, 32'hCD, "R12 threshold");
    wr_reg(12'h04C, 32'h3);
    rd_reg(12'h04C, 32'h1, "R12 protection");
    wr_reg(12'h050, 32'hF);
    rd_reg(12'h050, 32'h3, "R12 idle");

    // R10 autoidle
    wr_reg(12'h010, 32'h1);
    rd_reg(12'h010, 32'h1, "R10 config");
    chk_bit(autoidle, 1'b1, "R10 autoidle_o");

    // R3 clear port, R2 set port, R4 ignored writes
    wr_reg(12'h0A8, 32'h0000_00F0);
    rd_reg(12'h0A4, 32'hFFFF_FF0F, "R3 clear bits");
    wr_reg(12'h0A8, 32'h0);
    rd_reg(12'h0A4, 32'hFFFF_FF0F, "R3 zero clear");
    wr_reg(12'h0AC, 32'h0000_0010);
    rd_reg(12'h0A4, 32'hFFFF_FF1F, "R2 set bit");
    wr_reg(12'h0A4, 32'h0);
    wr_reg(12'h0B8, 32'hFFFF_FFFF);
    rd_reg(12'h0A4, 32'hFFFF_FF1F, "R4 mask write ignored");

    // R4 pending, R6 irq, R7 active number
    src[36] = 1'b1;
    src[37] = 1'b1;
    idle(2);
    rd_reg(12'h0B8, 32'h0000_0020, "R4 pending bank1");
    chk_bit(irq, 1'b1, "R6 irq high");
    rd_reg(12'h040, 32'h25, "R7 active 37");

    // R6 frozen selection
    src[5] = 1'b1;
    wr_reg(12'h088, 32'h20);
    idle(1);
    rd_reg(12'h040, 32'h25, "R6 frozen");
    chk_bit(irq, 1'b1, "R6 irq held");
    rd_reg(12'h098, 32'h20, "R4 pending bank0");

    // R8 acknowledge, R5 priority
    wr_reg(12'h048, 32'h1);
    chk_bit(irq, 1'b0, "R8 irq drops");
    idle(1);
    chk_bit(irq, 1'b1, "R8 reselect");
    rd_reg(12'h040, 32'h05, "R5 higher prio");

    // R7 spurious
    src[5] = 1'b0;
    idle(1);
    rd_reg(12'h040, 32'hFFFF_FF85, "R7 spurious");
    wr_reg(12'h048, 32'h1);
    idle(1);
    rd_reg(12'h040, 32'h25, "R8 next 37");

    // R5 priority and tie
    src[38] = 1'b1;
    wr_reg(12'h198, 32'd10);
    wr_reg(12'h048, 32'h1);
    idle(1);
    rd_reg(12'h040, 32'h26, "R5 prio wins");
    wr_reg(12'h194, 32'd10);
    wr_reg(12'h048, 32'h1);
    idle(1);
    rd_reg(12'h040, 32'h25, "R5 tie low");

    // R13 unmapped
    rd_reg(12'h3F0, 32'h0, "R13 unmapped");
    rd_reg(12'h094, 32'h0, "R13 bank hole");
    rd_reg(12'h280, 32'h0, "R13 past prio");

    // R9 soft reset
    wr_reg(12'h010, 32'h2);
    wr_reg(12'h0A8, 32'hFFFF_FFFF);
    rd_reg(12'h014, 32'h0, "R9 busy");
    idle(6);
    rd_reg(12'h014, 32'h1, "R9 done");
    rd_reg(12'h010, 32'h0, "R9 config cleared");
    rd_reg(12'h0A4, 32'hFFFF_FFFF, "R9 masked, write ignored");
    rd_reg(12'h198, 32'h0, "R9 prio cleared");
    rd_reg(12'h068, 32'h0, "R9 threshold cleared");
    chk_bit(irq, 1'b0, "R9 irq low");
    rd_reg(12'h040, 32'hFFFF_FF80, "R9 latch cleared");

    idle(3);
    summary();
  end

endmodule